// File: doc/BRIEF.md
# Per-CPU Doorbell Unit

This block keeps a bank of 32 doorbell bits for every CPU and turns them into two interrupt lines per CPU. A single shared trigger location raises doorbells. One write to it carries a bitmap of target CPUs and a doorbell number, so one store can post an inter-processor signal to several cores at once. Because the encoding is self-contained, a PCIe endpoint can also use the same location as its message-signalled-interrupt address: the message data names both the core and the vector.

Each CPU sees its own pending register and its own enable register through banked offsets, selected by a CPU-ID input on the register interface. Doorbells 0 to 7 are inter-processor doorbells and feed that CPU's IPI line. Doorbells 16 to 31 are MSI doorbells and feed its MSI line. Doorbells 8 to 15 are reserved. Software acknowledges a doorbell by writing a word whose bit for that doorbell is 0, with all other bits 1, so it cannot disturb doorbells that arrive between its read and its write.

Top module: `doorbell_unit`

## Requirements
- R1: A write to offset 0x04 sets pending bit `wdata[4:0]` on every CPU n for which `wdata[8+n]` is 1, and leaves the pending bits of all other CPUs unchanged.
- R2: A trigger whose doorbell number is 8 to 15 changes no pending bit, and pending bits 15:8 always read as 0.
- R3: A write to offset 0x08 from CPU c clears each pending bit of CPU c that is written as 0 and keeps each bit written as 1. The pending bits of other CPUs do not change.
- R4: Offset 0x08 reads the pending bits of the accessing CPU. Offset 0x0C writes and reads the enable bits of the accessing CPU only, and enable bits 15:8 read as 0.
- R5: `ipi_irq[c]` is 1 exactly when some bit in 7:0 is both pending and enabled for CPU c.
- R6: `msi_irq[c]` is 1 exactly when some bit in 31:16 is both pending and enabled for CPU c.
- R7: After reset every pending and enable bit is 0 and all interrupt outputs are low.
- R8: Read data appears on `bus_rdata` in the cycle after `bus_rd`. A read of the trigger offset or of any unmapped offset returns 0.
- R9: The MSI data word `(1 << (cpu+8)) | (16+v)`, written to 0x04, sets pending bit 16+v on that CPU only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_cpu | input | CPU_W | ID of the accessing CPU, selects the bank for 0x08 and 0x0C |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ipi_irq | output | NUM_CPU | Per-CPU inter-processor doorbell summary |
| msi_irq | output | NUM_CPU | Per-CPU MSI doorbell summary |

## Verification
The assertions assume that the bus issues at most one write per cycle, so a trigger and a pending-bit clear never land in the same cycle. They also assume that `bus_cpu` names a CPU that exists. The stimulus keeps to this by using a single driver task that issues one access at a time, and by drawing CPU IDs only from 0 to NUM_CPU-1. Target bitmaps may still carry bits above the last CPU, and those bits must be ignored.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    localparam int DB_W   = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_TRIG  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h0C;

    localparam int TGT_LSB = 8;
    localparam int TGT_W   = 8;
    localparam int IPI_LO  = 0;
    localparam int IPI_HI  = 7;
    localparam int MSI_LO  = 16;
    localparam int MSI_HI  = 31;

    localparam logic [DB_W-1:0] DB_LIVE = 32'hFFFF_00FF;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_TRIG,
        ACC_CAUSE,
        ACC_MASK
    } acc_e;

    typedef struct packed {
        logic            wr_cause;
        logic            wr_mask;
        logic [DB_W-1:0] data;
    } bank_wr_t;

    function automatic acc_e decode_off(input logic [ADDR_W-1:0] a);
        case (a)
            OFF_TRIG:  return ACC_TRIG;
            OFF_CAUSE: return ACC_CAUSE;
            OFF_MASK:  return ACC_MASK;
            default:   return ACC_NONE;
        endcase
    endfunction

    function automatic logic db_usable(input logic [4:0] n);
        return DB_LIVE[n];
    endfunction

endpackage

// File: rtl/db_bus_decode.sv
module db_bus_decode
    import doorbell_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DB_W-1:0]                wdata_i,
    input  logic [CPU_W-1:0]               cpu_i,
    output logic [NUM_CPU-1:0][DB_W-1:0]   set_o,
    output bank_wr_t [NUM_CPU-1:0]         bwr_o
);

    acc_e            kind;
    logic [4:0]      db_num;
    logic [DB_W-1:0] db_onehot;
    logic            trig_ok;

    always_comb begin
        kind      = wr_i ? decode_off(addr_i) : ACC_NONE;
        db_num    = wdata_i[4:0];
        db_onehot = {{(DB_W-1){1'b0}}, 1'b1} << db_num;
        trig_ok   = (kind == ACC_TRIG) && db_usable(db_num);
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        always_comb begin
            set_o[c] = (trig_ok && wdata_i[TGT_LSB + c]) ? db_onehot : '0;
            bwr_o[c].wr_cause = (kind == ACC_CAUSE) && (int'(cpu_i) == c);
            bwr_o[c].wr_mask  = (kind == ACC_MASK)  && (int'(cpu_i) == c);
            bwr_o[c].data     = wdata_i;
        end
    end

endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
    import doorbell_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [DB_W-1:0] set_i,
    input  bank_wr_t        bwr_i,
    output logic [DB_W-1:0] cause_o,
    output logic [DB_W-1:0] mask_o,
    output logic            ipi_o,
    output logic            msi_o
);

    logic [DB_W-1:0] cause_q, cause_d;
    logic [DB_W-1:0] mask_q, mask_d;
    logic [DB_W-1:0] live;

    always_comb begin
        cause_d = cause_q;
        if (bwr_i.wr_cause) begin
            cause_d = cause_d & bwr_i.data;
        end
        cause_d = (cause_d | set_i) & DB_LIVE;
        mask_d  = bwr_i.wr_mask ? (bwr_i.data & DB_LIVE) : mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
        end else begin
            cause_q <= cause_d;
            mask_q  <= mask_d;
        end
    end

    assign live    = cause_q & mask_q;
    assign ipi_o   = |live[IPI_HI:IPI_LO];
    assign msi_o   = |live[MSI_HI:MSI_LO];
    assign cause_o = cause_q;
    assign mask_o  = mask_q;

    AST_TRIG_SETS: assert property (@(posedge clk) disable iff (rst)
        (set_i != '0) |=> ((cause_q & $past(set_i)) == $past(set_i))) else $error("trigger lost"); // R1
    AST_CLEAR_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (bwr_i.wr_cause && set_i == '0) |=> ((cause_q & ~$past(bwr_i.data)) == '0)) else $error("clear failed"); // R3
    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bwr_i.wr_cause && set_i == '0) |=> $stable(cause_q)) else $error("pending changed"); // R1
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bwr_i.wr_mask) |=> $stable(mask_q)) else $error("enable changed"); // R4

endmodule

// File: rtl/db_read_mux.sv
module db_read_mux
    import doorbell_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [CPU_W-1:0]             cpu_i,
    input  logic [NUM_CPU-1:0][DB_W-1:0] cause_i,
    input  logic [NUM_CPU-1:0][DB_W-1:0] mask_i,
    output logic [DB_W-1:0]              rdata_o
);

    logic [DB_W-1:0] sel_d;
    logic            cpu_ok;

    always_comb begin
        cpu_ok = int'(cpu_i) < NUM_CPU;
        sel_d  = '0;
        if (cpu_ok) begin
            case (decode_off(addr_i))
                ACC_CAUSE: sel_d = cause_i[cpu_i];
                ACC_MASK:  sel_d = mask_i[cpu_i];
                default:   sel_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            rdata_o <= sel_d;
        end
    end

endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
    import doorbell_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DB_W-1:0]    bus_wdata,
    output logic [DB_W-1:0]    bus_rdata,
    output logic [NUM_CPU-1:0] ipi_irq,
    output logic [NUM_CPU-1:0] msi_irq
);

    logic [NUM_CPU-1:0][DB_W-1:0] set_v;
    bank_wr_t [NUM_CPU-1:0]       bwr_v;
    logic [NUM_CPU-1:0][DB_W-1:0] cause_v;
    logic [NUM_CPU-1:0][DB_W-1:0] mask_v;
    logic [NUM_CPU-1:0]           clr_sel;

    db_bus_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_dec (
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .cpu_i   (bus_cpu),
        .set_o   (set_v),
        .bwr_o   (bwr_v)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        db_cpu_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .set_i   (set_v[c]),
            .bwr_i   (bwr_v[c]),
            .cause_o (cause_v[c]),
            .mask_o  (mask_v[c]),
            .ipi_o   (ipi_irq[c]),
            .msi_o   (msi_irq[c])
        );
        assign clr_sel[c] = bwr_v[c].wr_cause;

        AST_ONE_DB_PER_CPU: assert property (@(posedge clk) disable iff (rst)
            $countones(set_v[c]) <= 1) else $error("multiple doorbells"); // R1
        AST_RSVD_TRIG: assert property (@(posedge clk) disable iff (rst)
            (set_v[c][MSI_LO-1:IPI_HI+1] == '0)) else $error("reserved doorbell set"); // R2
    end

    db_read_mux #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_i    (bus_rd),
        .addr_i  (bus_addr),
        .cpu_i   (bus_cpu),
        .cause_i (cause_v),
        .mask_i  (mask_v),
        .rdata_o (bus_rdata)
    );

    AST_SINGLE_BANK: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_sel)) else $error("two banks cleared"); // R3
    AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd) |=> $stable(bus_rdata)) else $error("rdata moved"); // R8

endmodule

// File: tb/doorbell_unit_bench.sv
module doorbell_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCPU       = 4;
    localparam int CW         = 2;
    localparam logic [31:0] LIVE = 32'hFFFF_00FF;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [CW-1:0]   bus_cpu = '0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCPU-1:0] ipi_irq;
    logic [NCPU-1:0] msi_irq;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_cause [NCPU];
    logic [31:0] m_mask  [NCPU];

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t exp_q[$];
    logic     rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    doorbell_unit #(.NUM_CPU(NCPU)) u_doorbell_unit (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_cpu   (bus_cpu),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ipi_irq   (ipi_irq),
        .msi_irq   (msi_irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // monitor: compares read data one cycle after the read strobe
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R8: unexpected read data %08h expected none", bus_rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic do_write(input int cpu, input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu = CW'(cpu); bus_addr = addr; bus_wdata = data;
        case (addr)
            8'h04: begin
                if (LIVE[data[4:0]]) begin
                    for (int c = 0; c < NCPU; c++)
                        if (data[8+c]) m_cause[c] = m_cause[c] | (32'h1 << data[4:0]);
                end
            end
            8'h08: m_cause[cpu] = m_cause[cpu] & data;
            8'h0C: m_mask[cpu] = data & LIVE;
            default: ;
        endcase
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input int cpu, input logic [7:0] addr, input logic [31:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = exp; it.tag = tag;
        exp_q.push_back(it);
        bus_rd = 1'b1; bus_cpu = CW'(cpu); bus_addr = addr;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] model_read(input int cpu, input logic [7:0] addr);
        if (addr == 8'h08) return m_cause[cpu];
        if (addr == 8'h0C) return m_mask[cpu];
        return 32'h0;
    endfunction

    task automatic check_irqs(input string tag);
        logic [NCPU-1:0] e_ipi, e_msi;
        for (int c = 0; c < NCPU; c++) begin
            e_ipi[c] = |(m_cause[c][7:0] & m_mask[c][7:0]);
            e_msi[c] = |(m_cause[c][31:16] & m_mask[c][31:16]);
        end
        check({tag, " R5 ipi"}, 32'(ipi_irq), 32'(e_ipi));
        check({tag, " R6 msi"}, 32'(msi_irq), 32'(e_msi));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : driver
        logic [31:0] lfsr;
        for (int c = 0; c < NCPU; c++) begin
            m_cause[c] = '0;
            m_mask[c]  = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R7 reset state
        check("R7 ipi after reset", 32'(ipi_irq), 32'h0);
        check("R7 msi after reset", 32'(msi_irq), 32'h0);
        do_read(0, 8'h08, 32'h0, "R7 pending reset");
        do_read(3, 8'h0C, 32'h0, "R7 enable reset");

        // R4 enable register, reserved bits read zero
        do_write(0, 8'h0C, 32'hFFFF_FFFF);
        do_read(0, 8'h0C, 32'hFFFF_00FF, "R4 enable readback");
        do_read(1, 8'h0C, 32'h0, "R4 other bank untouched");

        // R1 trigger doorbell 3 on CPUs 0 and 2
        do_write(1, 8'h04, 32'h0000_0503);
        check_irqs("R1 ipi multicast");
        check("R5 cpu0 raised", 32'(ipi_irq[0]), 32'h1);
        check("R5 cpu2 masked", 32'(ipi_irq[2]), 32'h0);
        do_read(2, 8'h08, 32'h0000_0008, "R1 cpu2 pending");
        do_read(1, 8'h08, 32'h0, "R1 cpu1 not targeted");

        // R9 MSI encoding: cpu1 vector 5
        do_write(1, 8'h0C, 32'h0020_0000);
        do_write(0, 8'h04, (32'h1 << 9) | (16 + 5));
        check("R9 msi cpu1", 32'(msi_irq), 32'h2);
        check_irqs("R6 msi");
        do_read(1, 8'h08, 32'h0020_0000, "R9 cpu1 pending");

        // R2 reserved doorbell number
        do_write(0, 8'h04, 32'h0000_080A);
        do_read(3, 8'h08, 32'h0, "R2 reserved ignored");

        // R3 clear by zero, other bank untouched
        do_write(0, 8'h08, ~32'h8);
        check("R3 ipi cpu0 cleared", 32'(ipi_irq[0]), 32'h0);
        do_read(0, 8'h08, 32'h0, "R3 cpu0 pending");
        do_read(2, 8'h08, 32'h8, "R3 cpu2 kept");

        // R5 enable gating
        do_write(2, 8'h0C, 32'h8);
        check("R5 cpu2 enabled", 32'(ipi_irq[2]), 32'h1);
        do_write(2, 8'h0C, 32'h0);
        check("R5 cpu2 disabled", 32'(ipi_irq[2]), 32'h0);

        // R3 write zero clears all
        do_write(1, 8'h08, 32'h0);
        check("R3 msi cpu1 cleared", 32'(msi_irq[1]), 32'h0);

        // R8 trigger and unmapped offsets read zero
        do_read(0, 8'h04, 32'h0, "R8 trigger reads zero");
        do_read(0, 8'h20, 32'h0, "R8 unmapped reads zero");

        // mixed patterns
        lfsr = 32'hACE1_2357;
        for (int i = 0; i < 300; i++) begin
            int cpu;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cpu = int'(lfsr[17:16]);
            case (lfsr[19:18])
                2'd0, 2'd1: do_write(cpu, 8'h04, {16'h0, lfsr[15:8], 3'b000, lfsr[4:0]});
                2'd2: do_write(cpu, 8'h08, ~(32'h1 << lfsr[24:20]));
                default: do_write(cpu, 8'h0C, lfsr);
            endcase
            check_irqs("R5 R6 mixed");
            do_read(cpu, 8'h08, model_read(cpu, 8'h08), "R1 R2 R3 mixed pending");
            do_read(cpu, 8'h0C, model_read(cpu, 8'h0C), "R4 mixed enable");
        end

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8: %0d reads unanswered expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule